// File: doc/BRIEF.md
# Pseudo-Static DRAM Sequencer with Hidden Refresh

This block connects a synchronous host request port to a byte-wide pseudo-static DRAM. The memory has a static-RAM style pinout: an active-low chip enable, output enable and write enable, 19 address lines that are not multiplexed, and an 8-bit data bus. The host presents one request at a time with a valid/ready handshake. Each request carries an address, a write flag and write data. The sequencer turns each request into a timed device cycle, and read results come back as a one-cycle valid pulse.

Inside the memory the cells are dynamic, and the sequencer hides that from the host. A free-running interval timer raises a refresh request. The sequencer serves it by pulsing output enable low while chip enable stays high, and the device supplies the refresh row itself. A refresh that is waiting outranks any request not yet accepted.

The address splits into an 11-bit row, `addr[18:8]`, and an 8-bit column, `addr[7:0]`. When a request arrives in the cycle right after an access and targets the same row, it runs as a short in-row access with no precharge. Any other access is a full cycle: an access phase, then a precharge with every strobe high. With no work pending, the device sits in standby with chip enable and output enable both high.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` and `rd_valid` are 0, and `refresh_count` is 0.
- R2: A read returns the byte at its address on `rd_data` with `rd_valid` high for exactly one cycle. If the request was accepted from standby (chip enable high at acceptance), `rd_valid` rises T_ACC+1 cycles after the acceptance cycle.
- R3: `mem_we_n` is low only while `mem_ce_n` is low, `mem_oe_n` is high and `mem_dq_oe` is 1. Each write holds `mem_we_n` low for T_ACC-2 consecutive cycles. `mem_dq_oe` is 1 only during write cycles.
- R4: Every time `mem_ce_n` falls, it has been high for at least T_PRE cycles just before.
- R5: A request accepted while chip enable is still low from the previous access, with the same row bits `addr[18:8]`, keeps chip enable low. A read of this kind raises `rd_valid` T_PAGE+1 cycles after acceptance.
- R6: A request accepted while chip enable is low but with a different row goes through precharge first. A read of this kind raises `rd_valid` T_PRE+T_ACC+1 cycles after acceptance.
- R7: A refresh strobe holds `mem_oe_n` low with `mem_ce_n` high for exactly T_RFS cycles. Over any run, the number of strobes is within one of the elapsed cycles divided by REF_INTERVAL.
- R8: A refresh strobe starts only after chip enable has been high for at least T_PRE cycles. `req_ready` is 0 during a strobe.
- R9: With no host request outstanding, `mem_ce_n` stays high. Whenever `req_ready` is 1 with `mem_ce_n` high, `mem_oe_n` and `mem_we_n` are high.
- R10: `refresh_count` goes up by exactly one in the cycle each refresh strobe starts, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_addr | input | 19 | Byte address, row in bits 18:8 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 8 | Read result |
| mem_addr | output | 19 | Device address |
| mem_dq_out | output | 8 | Byte driven to the device |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 8 | Byte returned by the device |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low; alone it requests refresh |
| mem_we_n | output | 1 | Write enable, active low |
| refresh_count | output | 16 | Number of refresh strobes issued |

## Verification
The bench streams requests back to back over a few rows, so that same-row and different-row requests often land in the cycle right after an access. For every read it predicts the latency from the chip-enable level and row at acceptance. A design that skipped the in-row shortcut, or that used it across a row change, would return reads 3 cycles late or 3 cycles early.

A refresh falls due while a request is waiting in most intervals. A design that let the strobe overlap chip enable, or that cut short the precharge before it, would fail the strobe-shape and idle-length checks. Bytes written through the strobe model are read back and compared. A write enable pulse outside the enabled window would lose data or corrupt the wrong address.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;
    localparam int COL_W  = 8;
    localparam int ROW_W  = ADDR_W - COL_W;

    typedef enum logic [2:0] {
        SQ_STANDBY,   // all strobes high, may start access or refresh
        SQ_FULL,      // random access phase
        SQ_INROW,     // short access within the open row
        SQ_HOLD,      // one cycle with row held open, chip enabled
        SQ_RECOVER,   // precharge, all strobes high
        SQ_REFRESH    // output-enable-only strobe
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] data;
    } host_req_t;

    function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:COL_W];
    endfunction

endpackage

// File: rtl/psram_refresh_timer.sv
module psram_refresh_timer #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst,
    input  logic grant,
    output logic pending
);
    localparam int TW = $clog2(INTERVAL);

    logic [TW-1:0] tick_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= TW'(INTERVAL - 1);
            pending  <= 1'b0;
        end else if (tick_cnt == '0) begin
            tick_cnt <= TW'(INTERVAL - 1);
            pending  <= 1'b1;
        end else begin
            tick_cnt <= tick_cnt - 1'b1;
            if (grant) pending <= 1'b0;
        end
    end

endmodule

// File: rtl/psram_row_track.sv
module psram_row_track #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             hit
);
    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk) begin
        if (rst)       open_row <= '0;
        else if (load) open_row <= load_row;
    end

    assign hit = (open_row == cmp_row);

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int T_ACC        = 4,
    parameter int T_PAGE       = 4,
    parameter int T_PRE        = 3,
    parameter int T_RFS        = 4,
    parameter int REF_INTERVAL = 781,
    parameter int CNT_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [CNT_W-1:0]  refresh_count
);
    localparam int CW = $clog2(T_ACC + T_PAGE + T_PRE + T_RFS + 1);

    seq_state_e    st;
    logic [CW-1:0] tmr;
    host_req_t     cur;
    host_req_t     incoming;
    logic          queued;
    logic          ref_pend;
    logic          ref_grant;
    logic          row_hit;
    logic          accept;
    logic          in_access;
    logic [CW-1:0] first_tick;

    assign incoming  = '{addr: req_addr, wr: req_write, data: req_wdata};
    assign req_ready = !ref_pend && (st == SQ_STANDBY || st == SQ_HOLD);
    assign accept    = req_valid && req_ready;
    assign ref_grant = (st == SQ_STANDBY) && ref_pend;

    psram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .grant   (ref_grant),
        .pending (ref_pend)
    );

    psram_row_track #(.ROW_W(ROW_W)) u_rows (
        .clk      (clk),
        .rst      (rst),
        .load     (st == SQ_FULL),
        .load_row (row_of(cur.addr)),
        .cmp_row  (row_of(req_addr)),
        .hit      (row_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= SQ_STANDBY;
            tmr           <= '0;
            cur           <= '0;
            queued        <= 1'b0;
            rd_valid      <= 1'b0;
            rd_data       <= '0;
            refresh_count <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (st)
                SQ_STANDBY: begin
                    if (ref_pend) begin
                        st            <= SQ_REFRESH;
                        tmr           <= CW'(T_RFS - 1);
                        refresh_count <= refresh_count + 1'b1;
                    end else if (accept) begin
                        cur <= incoming;
                        st  <= SQ_FULL;
                        tmr <= CW'(T_ACC - 1);
                    end
                end
                SQ_FULL, SQ_INROW: begin
                    if (tmr == '0) begin
                        if (!cur.wr) begin
                            rd_data  <= mem_dq_in;
                            rd_valid <= 1'b1;
                        end
                        st <= SQ_HOLD;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                SQ_HOLD: begin
                    if (accept && row_hit) begin
                        cur <= incoming;
                        st  <= SQ_INROW;
                        tmr <= CW'(T_PAGE - 1);
                    end else begin
                        if (accept) cur <= incoming;
                        queued <= accept;
                        st     <= SQ_RECOVER;
                        tmr    <= CW'(T_PRE - 1);
                    end
                end
                SQ_RECOVER: begin
                    if (tmr == '0) begin
                        queued <= 1'b0;
                        st     <= queued ? SQ_FULL : SQ_STANDBY;
                        tmr    <= CW'(T_ACC - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                SQ_REFRESH: begin
                    if (tmr == '0) begin
                        queued <= 1'b0;
                        st     <= SQ_RECOVER;
                        tmr    <= CW'(T_PRE - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: st <= SQ_STANDBY;
            endcase
        end
    end

    assign in_access  = (st == SQ_FULL) || (st == SQ_INROW);
    assign first_tick = (st == SQ_FULL) ? CW'(T_ACC - 1) : CW'(T_PAGE - 1);

    assign mem_ce_n   = !(in_access || st == SQ_HOLD);
    assign mem_oe_n   = !((in_access && !cur.wr) || st == SQ_REFRESH);
    assign mem_we_n   = !(in_access && cur.wr && tmr != first_tick && tmr != '0);
    assign mem_dq_oe  = in_access && cur.wr;
    assign mem_addr   = cur.addr;
    assign mem_dq_out = cur.data;

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
    parameter int T_PRE = 3,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             rd_valid,
    input logic             mem_dq_oe,
    input logic             mem_ce_n,
    input logic             mem_oe_n,
    input logic             mem_we_n,
    input logic [CNT_W-1:0] refresh_count
);
    logic [7:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)           hi_run <= 8'(T_PRE);
        else if (!mem_ce_n) hi_run <= '0;
        else if (hi_run != 8'hFF) hi_run <= hi_run + 1'b1;
    end

    assert_we_window_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    assert_bus_drive_R3: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

    assert_precharge_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> (hi_run >= 8'(T_PRE)));

    assert_refresh_gap_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_oe_n) && mem_ce_n) |-> (hi_run >= 8'(T_PRE)));

    assert_no_ready_refresh_R8: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n && mem_ce_n) |-> !req_ready);

    assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_oe_n) && mem_ce_n) |-> refresh_count == CNT_W'($past(refresh_count) + 1'b1));

    assert_count_only_R10: assert property (@(posedge clk) disable iff (rst)
        (refresh_count != $past(refresh_count)) |-> (!mem_oe_n && mem_ce_n));

    assert_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    assert_standby_R9: assert property (@(posedge clk) disable iff (rst)
        (req_ready && mem_ce_n) |-> (mem_oe_n && mem_we_n));

endmodule

bind psram_ctrl psram_ctrl_chk #(.T_PRE(T_PRE), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_ready     (req_ready),
    .rd_valid      (rd_valid),
    .mem_dq_oe     (mem_dq_oe),
    .mem_ce_n      (mem_ce_n),
    .mem_oe_n      (mem_oe_n),
    .mem_we_n      (mem_we_n),
    .refresh_count (refresh_count)
);

// File: tb/sim_psram_ctrl.sv
module sim_psram_ctrl;
    localparam int T_ACC  = 4;
    localparam int T_PAGE = 4;
    localparam int T_PRE  = 3;
    localparam int T_RFS  = 4;
    localparam int REF_IV = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [18:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in = '0;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [15:0] refresh_count;

    psram_ctrl #(.T_ACC(T_ACC), .T_PAGE(T_PAGE), .T_PRE(T_PRE), .T_RFS(T_RFS),
                 .REF_INTERVAL(REF_IV), .CNT_W(16)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .refresh_count(refresh_count)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cyc0   = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "R2", "watchdog expired", cyc, 150000);
            summary();
            $finish;
        end
    end

    // device model: write strobe stores, output enable returns stored byte
    logic [7:0] dev [int];
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) dev[int'(mem_addr)] = mem_dq_out;
        if (!mem_ce_n && !mem_oe_n && dev.exists(int'(mem_addr)))
            mem_dq_in <= dev[int'(mem_addr)];
        else
            mem_dq_in <= 8'h00;
    end

    // pin monitors
    int  hi_run = 100;
    int  ref_len = 0, we_len = 0, strobes = 0;
    int  r3_bad = 0;
    bit  idle_win = 0;
    int  idle_bad = 0;
    logic p_ce = 1, p_oe = 1, p_we = 1;
    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_ce_n && p_ce)
                check(hi_run >= T_PRE, "R4", "precharge cycles before enable", hi_run, T_PRE);
            if (mem_ce_n && !mem_oe_n && p_oe) begin
                strobes++;
                check(hi_run >= T_PRE, "R8", "idle cycles before refresh", hi_run, T_PRE);
                check(!req_ready, "R8", "ready during refresh", req_ready, 0);
            end
            if (mem_ce_n && !mem_oe_n) ref_len++;
            else if (ref_len != 0) begin
                check(ref_len == T_RFS, "R7", "refresh strobe length", ref_len, T_RFS);
                ref_len = 0;
            end
            if (!mem_we_n) begin
                we_len++;
                if (mem_ce_n || !mem_oe_n || !mem_dq_oe) r3_bad++;
            end else if (!p_we) begin
                check(we_len == T_ACC - 2, "R3", "write strobe length", we_len, T_ACC - 2);
                we_len = 0;
            end
            if (mem_dq_oe && (mem_ce_n || !mem_oe_n)) r3_bad++;
            if (idle_win && !mem_ce_n) idle_bad++;
            hi_run = mem_ce_n ? hi_run + 1 : 0;
        end
        p_ce = mem_ce_n; p_oe = mem_oe_n; p_we = mem_we_n;
    end

    // read scoreboard
    logic [7:0] ref_mem [int];
    logic [7:0] q_data[$];
    int         q_due[$];
    string      q_tag[$];
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R2", "unexpected read strobe", 1, 0);
            end else begin
                check(rd_data == q_data[0], "R2", "read data", rd_data, q_data[0]);
                check(cyc == q_due[0], q_tag[0], "read completion cycle", cyc, q_due[0]);
                void'(q_data.pop_front());
                void'(q_due.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    logic [10:0] last_row = '0;

    task automatic issue(input logic [18:0] a, input bit w, input logic [7:0] d);
        int lat;
        string tag;
        req_addr = a; req_write = w; req_wdata = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        if (mem_ce_n) begin
            lat = T_ACC + 1; tag = "R2";
        end else if (a[18:8] == last_row) begin
            lat = T_PAGE + 1; tag = "R5";
        end else begin
            lat = T_PRE + T_ACC + 1; tag = "R6";
        end
        if (w) begin
            ref_mem[int'(a)] = d;
        end else begin
            q_data.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
            q_due.push_back(cyc + lat);
            q_tag.push_back(tag);
        end
        last_row = a[18:8];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [18:0] pick_addr(input logic [10:0] prev);
        logic [10:0] rows [4] = '{11'd5, 11'd6, 11'h7FF, 11'd0};
        logic [10:0] r;
        r = ($urandom % 2 == 0) ? prev : rows[$urandom % 4];
        return {r, 8'($urandom % 16)};
    endfunction

    initial begin
        int exp_lo, exp_hi, expect_n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 during reset
        check(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes in reset",
              {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        check(!mem_dq_oe && !rd_valid, "R1", "drive and valid in reset", {mem_dq_oe, rd_valid}, 0);
        rst = 1'b0;
        cyc0 = cyc;
        @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes after reset",
              {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        check(refresh_count == 0, "R1", "refresh count after reset", refresh_count, 0);

        // directed: write then same-row read, unwritten column, row change
        issue({11'd5, 8'd3}, 1'b1, 8'hA5);
        issue({11'd5, 8'd3}, 1'b0, 8'h00);   // R5 same-row read
        issue({11'd5, 8'd9}, 1'b0, 8'h00);   // R5 unwritten byte
        issue({11'h7FF, 8'd3}, 1'b0, 8'h00); // R6 row change
        issue({11'd0, 8'd0}, 1'b1, 8'h3C);
        issue({11'd0, 8'd0}, 1'b0, 8'h00);
        repeat (20) @(negedge clk);
        issue({11'h7FF, 8'd255}, 1'b1, 8'hFF);
        repeat (8) @(negedge clk);
        issue({11'h7FF, 8'd255}, 1'b0, 8'h00); // R2 from standby

        // random stream
        for (int i = 0; i < 600; i++) begin
            issue(pick_addr(last_row), ($urandom % 3 == 0), 8'($urandom));
            if ($urandom % 8 == 0) repeat ($urandom % 7) @(negedge clk);
        end

        while (q_data.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
        // R9 idle window
        idle_win = 1'b1;
        repeat (60) @(negedge clk);
        idle_win = 1'b0;
        check(idle_bad == 0, "R9", "enabled cycles while idle", idle_bad, 0);
        check(r3_bad == 0, "R3", "strobe or drive outside write window", r3_bad, 0);

        // R7 rate and R10 count
        expect_n = (cyc - cyc0) / REF_IV;
        exp_lo = expect_n - 1;
        exp_hi = expect_n + 1;
        check(strobes >= exp_lo && strobes <= exp_hi, "R7", "refresh strobes in run",
              strobes, expect_n);
        check(int'(refresh_count) == strobes, "R10", "refresh counter", refresh_count, strobes);

        summary();
        $finish;
    end

endmodule